// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with two or three separate down-counting channels. Every channel has three registers: a reload value, a live count and a 16-bit control word. One shared byte register holds a run bit for each channel. While its run bit is set, a channel decrements its count once per prescaled tick. When the count is already zero, the next tick reloads it from the reload value and latches an underflow flag. Each channel drives its own level interrupt.

Software uses the block in two ways. For a periodic or one-shot event it programs a reload value and a count, enables the interrupt, and acknowledges each event by rewriting the control word. For a free-running time base it loads all ones into both registers and reads the elapsed time as the inverted count.

Each channel has one state machine with two states. `CH_STOP` holds the count and keeps the prescaler at zero. `CH_RUN` lets prescaler ticks reach the counter. The transition `start` (STOP to RUN) is taken when the channel's run bit is 1. The transition `halt` (RUN to STOP) is taken when the run bit is 0. Both states hold otherwise. Counting is gated by the run bit as well as the state, so clearing the bit stops the count on the very next edge.

Top module: `tmr_unit_top`

## Requirements
- R1: After reset, the run register, every reload, count and control register, and every interrupt output read 0.
- R2: With `ALT_MAP`=0, the run register is at byte 4 and channel n occupies 8+12n (reload), 12+12n (count) and 16+12n (control). Reads of any other address return 0.
- R3: The run register keeps one bit per channel: bit n runs channel n. It reads back the stored bits, and bits at or above `NUM_CH` are ignored on write and read as 0.
- R4: With prescaler code 0, the first decrement lands on the 5th clock edge after the edge that writes the run bit, and further decrements follow every 4 edges.
- R5: Control bits [2:0] choose a divide of 4, 16, 64, 256 or 1024 for codes 0 to 4. Codes 5 to 7 divide by 1024 and read back as written.
- R6: A tick that finds the count at 0 reloads the count from the reload register and sets the underflow flag (control bit 8).
- R7: `irq[n]` is high exactly while channel n's flag and its interrupt enable (control bit 5) are both 1. It stays high after the channel is stopped.
- R8: A control write of 16 or 32 bits with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves the flag unchanged and never sets it.
- R9: A channel loaded with all ones in both its reload and count registers counts freely, and the inverted count equals the number of ticks elapsed.
- R10: A stopped channel holds its count. A count write while stopped is visible on the next read.
- R11: The prescaler restarts from zero whenever a channel starts. After a stop and a restart, the first decrement again lands on the 5th edge (code 0).
- R12: With `ALT_MAP`=1, the run register is at byte 2 and channel n's registers begin at 4+12n.
- R13: `bus_size` 0, 1 and 2 select 8, 16 and 32 bits. A write changes only the low 8, 16 or 32 bits of the addressed register, and a read returns those bits. A byte write to the control register leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, combinational, right-justified |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
A channel state machine stuck in `CH_STOP` shows at the ports as a count that stays frozen over the bench's observation window, which is about twenty edges at the fastest divide. A prescaler that keeps a stale phase shows as a decrement that lands one or more edges early after a restart, and the bench reads the count at the exact edge where this appears. A flag or enable that is set wrongly shows on `irq` in the same cycle as the control write, and the bench checks `irq` after every control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int PSC_W    = 3;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;
    localparam int DIV_W    = 10;

    // terminal value of the prescaler counter for a divide code
    function automatic logic [DIV_W-1:0] div_limit(input logic [PSC_W-1:0] code);
        logic [DIV_W:0] full;
        if (code > 3'd4) full = 11'd1024;
        else             full = 11'd4 << {code, 1'b0};
        return DIV_W'(full - 11'd1);
    endfunction

    // bit mask selected by the access size
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        logic [31:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    assign tick = !clear && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= '0;
        end else if (phase_q == limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic             wr_reload,
    input  logic             wr_count,
    input  logic             wr_ctrl,
    input  logic [31:0]      wmask,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic [15:0]      ctrl_rd,
    output logic             flag_q,
    output logic             counting,
    output logic             irq
);

    ch_state_e        state_q, state_d;
    logic [PSC_W-1:0] psc_q;
    logic             ie_q;
    logic             tick;
    logic             underflow;
    logic [CNT_W-1:0] mask_c;
    logic [CNT_W-1:0] data_c;

    assign mask_c = CNT_W'(wmask);
    assign data_c = CNT_W'(wdata);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        counting = 1'b0;
        unique case (state_q)
            CH_STOP: begin
                if (run_bit) state_d = CH_RUN;
            end
            CH_RUN: begin
                counting = run_bit;
                if (!run_bit) state_d = CH_STOP;
            end
            default: state_d = CH_STOP;
        endcase
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!counting),
        .limit (div_limit(psc_q)),
        .tick  (tick)
    );

    assign underflow = tick && (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            psc_q    <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= (reload_q & ~mask_c) | (data_c & mask_c);

            if (wr_count)       count_q <= (count_q & ~mask_c) | (data_c & mask_c);
            else if (underflow) count_q <= reload_q;
            else if (tick)      count_q <= count_q - 1'b1;

            if (wr_ctrl) begin
                psc_q <= wdata[PSC_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end

            if (underflow)
                flag_q <= 1'b1;
            else if (wr_ctrl && wmask[FLAG_BIT] && !wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[PSC_W-1:0]     = psc_q;
        ctrl_rd[IE_BIT]        = ie_q;
        ctrl_rd[FLAG_BIT]      = flag_q;
    end

    assign irq = flag_q && ie_q;

endmodule

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
    parameter int NUM_CH  = 3,
    parameter int ADDR_W  = 8,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_run,
    output logic [NUM_CH-1:0] hit_reload,
    output logic [NUM_CH-1:0] hit_count,
    output logic [NUM_CH-1:0] hit_ctrl
);

    localparam int RUN_ADDR = ALT_MAP ? 2 : 4;
    localparam int CH_BASE  = ALT_MAP ? 4 : 8;
    localparam int CH_PITCH = 12;

    assign hit_run = (addr == ADDR_W'(RUN_ADDR));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH_BASE + CH_PITCH * i;
        assign hit_reload[i] = (addr == ADDR_W'(BASE));
        assign hit_count[i]  = (addr == ADDR_W'(BASE + 4));
        assign hit_ctrl[i]   = (addr == ADDR_W'(BASE + 8));
    end

endmodule

// File: rtl/tmr_unit_top.sv
module tmr_unit_top
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic                         hit_run;
    logic [NUM_CH-1:0]            hit_reload, hit_count, hit_ctrl;
    logic [NUM_CH-1:0]            run_q;
    logic [31:0]                  wmask;
    logic                         wr_go;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_reload;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][15:0]      ch_ctrl;
    logic [NUM_CH-1:0]            ch_flag;
    logic [NUM_CH-1:0]            ch_run;
    logic [31:0]                  rd_raw;

    assign wmask = size_mask(bus_size);
    assign wr_go = bus_sel && bus_wr;

    tmr_addr_dec #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .ALT_MAP (ALT_MAP)
    ) u_dec (
        .addr       (bus_addr),
        .hit_run    (hit_run),
        .hit_reload (hit_reload),
        .hit_count  (hit_count),
        .hit_ctrl   (hit_ctrl)
    );

    // shared run register, one bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= '0;
        else if (wr_go && hit_run) run_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_bit   (run_q[i]),
            .wr_reload (wr_go && hit_reload[i]),
            .wr_count  (wr_go && hit_count[i]),
            .wr_ctrl   (wr_go && hit_ctrl[i]),
            .wmask     (wmask),
            .wdata     (bus_wdata),
            .reload_q  (ch_reload[i]),
            .count_q   (ch_cnt[i]),
            .ctrl_rd   (ch_ctrl[i]),
            .flag_q    (ch_flag[i]),
            .counting  (ch_run[i]),
            .irq       (irq[i])
        );
    end

    always_comb begin
        rd_raw = '0;
        if (hit_run) rd_raw = 32'(run_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_reload[i]) rd_raw = 32'(ch_reload[i]);
            if (hit_count[i])  rd_raw = 32'(ch_cnt[i]);
            if (hit_ctrl[i])   rd_raw = 32'(ch_ctrl[i]);
        end
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? (rd_raw & wmask) : 32'h0;

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_sel,
    input logic                         bus_wr,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_reload,
    input logic [NUM_CH-1:0]            ch_flag,
    input logic [NUM_CH-1:0]            ch_run
);

    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R10: a stopped channel with no write keeps its count
        assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && !wr_any) |=> $stable(ch_cnt[i]));

        // R6: the flag rises only together with a reload of the count
        assert_reload_on_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ch_flag[i]) && !$past(wr_any)) |-> (ch_cnt[i] == ch_reload[i]));

        // R8: an interrupt goes away only through a register write
        assert_irq_drop_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[i]) |-> $past(wr_any));

        // R4: a running count holds, steps down by one or reloads after zero
        assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && !wr_any) |=>
                ((ch_cnt[i] == $past(ch_cnt[i])) ||
                 (ch_cnt[i] == $past(ch_cnt[i]) - CNT_W'(1)) ||
                 (($past(ch_cnt[i]) == '0) && (ch_cnt[i] == ch_reload[i]))));
    end

endmodule

bind tmr_unit_top tmr_unit_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .irq       (irq),
    .ch_cnt    (ch_cnt),
    .ch_reload (ch_reload),
    .ch_flag   (ch_flag),
    .ch_run    (ch_run)
);

// File: tb/sim_tmr_unit_top.sv
module sim_tmr_unit_top;

    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel0 = 1'b0, sel1 = 1'b0, bus_wr = 1'b0;
    logic [1:0]        bus_size = 2'd2;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rdata0, rdata1;
    logic [2:0]        irq0;
    logic [1:0]        irq1;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_unit_top #(.NUM_CH(3), .ADDR_W(ADDR_W), .ALT_MAP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .irq(irq0));

    tmr_unit_top #(.NUM_CH(2), .ADDR_W(ADDR_W), .ALT_MAP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .irq(irq1));

    // monitor: pops expected items and compares with observed results
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0) begin
            logic [31:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
        act_q.push_back(act);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input bit unit, input int addr, input logic [1:0] sz, input logic [31:0] d);
        bus_addr  = ADDR_W'(addr);
        bus_size  = sz;
        bus_wdata = d;
        bus_wr    = 1'b1;
        if (unit) sel1 = 1'b1; else sel0 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        sel0 = 1'b0; sel1 = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input bit unit, input int addr, input logic [1:0] sz, output logic [31:0] v);
        bus_addr = ADDR_W'(addr);
        bus_size = sz;
        bus_wr   = 1'b0;
        if (unit) sel1 = 1'b1; else sel0 = 1'b1;
        #1;
        v = unit ? rdata1 : rdata0;
        sel0 = 1'b0; sel1 = 1'b0;
    endtask

    task automatic chk_rd(input bit unit, input int addr, input logic [1:0] sz,
                          input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(unit, addr, sz, v);
        push(v, exp, tag);
    endtask

    // u0 default map addresses
    localparam int RUN0 = 4;
    function automatic int rl0(input int n); return 8 + 12*n;  endfunction
    function automatic int ct0(input int n); return 12 + 12*n; endfunction
    function automatic int cr0(input int n); return 16 + 12*n; endfunction

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk_rd(0, RUN0, 2'd0, 32'h0, "R1 run reg");
        chk_rd(0, rl0(0), 2'd2, 32'h0, "R1 reload0");
        chk_rd(0, ct0(0), 2'd2, 32'h0, "R1 count0");
        chk_rd(0, cr0(0), 2'd1, 32'h0, "R1 ctrl0");
        push(32'(irq0), 32'h0, "R1 irq u0");
        push(32'(irq1), 32'h0, "R1 irq u1");

        // R3 run register
        wr(0, RUN0, 2'd0, 32'h07);
        chk_rd(0, RUN0, 2'd0, 32'h07, "R3 all run");
        wr(0, RUN0, 2'd0, 32'hFF);
        chk_rd(0, RUN0, 2'd0, 32'h07, "R3 upper bits ignored");
        wr(0, RUN0, 2'd0, 32'h02);
        chk_rd(0, RUN0, 2'd0, 32'h02, "R3 single bit");
        wr(0, RUN0, 2'd0, 32'h00);
        chk_rd(0, RUN0, 2'd0, 32'h00, "R3 stop all");

        // R2 map and R13 access sizes on channel 2
        wr(0, rl0(2), 2'd2, 32'hAABBCCDD);
        chk_rd(0, rl0(2), 2'd2, 32'hAABBCCDD, "R2 reload2");
        wr(0, ct0(2), 2'd2, 32'h12345678);
        chk_rd(0, ct0(2), 2'd2, 32'h12345678, "R2 count2");
        wr(0, cr0(2), 2'd1, 32'h0024);
        chk_rd(0, cr0(2), 2'd1, 32'h0024, "R2 ctrl2");
        chk_rd(0, 0, 2'd2, 32'h0, "R2 unmapped 0");
        chk_rd(0, 44, 2'd2, 32'h0, "R2 unmapped 44");
        wr(0, rl0(2), 2'd0, 32'hFFFFFF11);
        chk_rd(0, rl0(2), 2'd2, 32'hAABBCC11, "R13 byte write");
        chk_rd(0, rl0(2), 2'd1, 32'h0000CC11, "R13 half read");
        chk_rd(0, rl0(2), 2'd0, 32'h00000011, "R13 byte read");

        // R4 decrement timing, code 0
        wr(0, cr0(0), 2'd1, 32'h0000);
        wr(0, ct0(0), 2'd2, 32'd100);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R10 immediate count write");
        wr(0, RUN0, 2'd0, 32'h01);
        idle(4);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R4 no decrement at edge 4");
        idle(1);
        chk_rd(0, ct0(0), 2'd2, 32'd99, "R4 first decrement edge 5");
        idle(15);
        chk_rd(0, ct0(0), 2'd2, 32'd96, "R4 edge 20");
        wr(0, RUN0, 2'd0, 32'h00);

        // R11 prescaler restart, R10 hold
        wr(0, ct0(0), 2'd2, 32'd100);
        wr(0, RUN0, 2'd0, 32'h01);
        idle(3);
        wr(0, RUN0, 2'd0, 32'h00);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R11 stopped before tick");
        idle(5);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R10 hold while stopped");
        wr(0, RUN0, 2'd0, 32'h01);
        idle(4);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R11 restart edge 4");
        idle(1);
        chk_rd(0, ct0(0), 2'd2, 32'd99, "R11 restart edge 5");
        wr(0, RUN0, 2'd0, 32'h00);

        // R5 divide by 16
        wr(0, cr0(0), 2'd1, 32'h0001);
        wr(0, ct0(0), 2'd2, 32'd100);
        wr(0, RUN0, 2'd0, 32'h01);
        idle(16);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R5 div16 edge 16");
        idle(1);
        chk_rd(0, ct0(0), 2'd2, 32'd99, "R5 div16 edge 17");
        wr(0, RUN0, 2'd0, 32'h00);

        // R5 reserved code 5 acts as 1024
        wr(0, cr0(0), 2'd1, 32'h0005);
        chk_rd(0, cr0(0), 2'd1, 32'h0005, "R5 code 5 readback");
        wr(0, ct0(0), 2'd2, 32'd100);
        wr(0, RUN0, 2'd0, 32'h01);
        idle(1024);
        chk_rd(0, ct0(0), 2'd2, 32'd100, "R5 code5 edge 1024");
        idle(1);
        chk_rd(0, ct0(0), 2'd2, 32'd99, "R5 code5 edge 1025");
        wr(0, RUN0, 2'd0, 32'h00);

        // R6 underflow, R7 interrupt, R8 clear rules
        wr(0, cr0(0), 2'd1, 32'h0020);
        wr(0, rl0(0), 2'd2, 32'd7);
        wr(0, ct0(0), 2'd2, 32'd2);
        wr(0, RUN0, 2'd0, 32'h01);
        idle(12);
        chk_rd(0, ct0(0), 2'd2, 32'd0, "R6 count at zero");
        push(32'(irq0[0]), 32'h0, "R7 irq low before underflow");
        idle(1);
        chk_rd(0, ct0(0), 2'd2, 32'd7, "R6 reload on underflow");
        chk_rd(0, cr0(0), 2'd1, 32'h0120, "R6 flag set");
        push(32'(irq0[0]), 32'h1, "R7 irq high");
        wr(0, RUN0, 2'd0, 32'h00);
        idle(10);
        push(32'(irq0[0]), 32'h1, "R7 irq level held when stopped");
        wr(0, cr0(0), 2'd1, 32'h0100);
        chk_rd(0, cr0(0), 2'd1, 32'h0100, "R7 enable off flag kept");
        push(32'(irq0[0]), 32'h0, "R7 irq masked");
        wr(0, cr0(0), 2'd1, 32'h0120);
        push(32'(irq0[0]), 32'h1, "R8 bit8 one keeps flag");
        wr(0, cr0(0), 2'd0, 32'h00);
        chk_rd(0, cr0(0), 2'd1, 32'h0100, "R13 byte ctrl write keeps flag");
        wr(0, cr0(0), 2'd1, 32'h0020);
        chk_rd(0, cr0(0), 2'd1, 32'h0020, "R8 flag cleared");
        push(32'(irq0[0]), 32'h0, "R8 irq cleared");
        wr(0, cr0(0), 2'd1, 32'h0120);
        chk_rd(0, cr0(0), 2'd1, 32'h0020, "R8 bit8 one never sets");

        // R9 free-running on channel 1
        wr(0, cr0(1), 2'd1, 32'h0000);
        wr(0, rl0(1), 2'd2, 32'hFFFFFFFF);
        wr(0, ct0(1), 2'd2, 32'hFFFFFFFF);
        wr(0, RUN0, 2'd0, 32'h02);
        idle(41);
        rd(0, ct0(1), 2'd2, v);
        push(~v, 32'd10, "R9 elapsed is inverted count");
        chk_rd(0, cr0(1), 2'd1, 32'h0000, "R9 no underflow");
        wr(0, RUN0, 2'd0, 32'h00);

        // R12 alternate map on u1
        wr(1, 2, 2'd0, 32'h03);
        chk_rd(1, 2, 2'd0, 32'h03, "R12 run reg at 2");
        wr(1, 2, 2'd0, 32'h00);
        wr(1, 16, 2'd2, 32'h00001234);
        chk_rd(1, 16, 2'd2, 32'h00001234, "R12 reload1 at 16");
        wr(1, 12, 2'd1, 32'h0003);
        chk_rd(1, 12, 2'd1, 32'h0003, "R12 ctrl0 at 12");
        wr(1, 20, 2'd2, 32'h00000055);
        chk_rd(1, 20, 2'd2, 32'h00000055, "R12 count1 at 20");
        chk_rd(1, 4, 2'd2, 32'h0, "R12 reload0 at 4");
        chk_rd(1, 28, 2'd2, 32'h0, "R12 beyond last channel");

        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule